// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Guarded Flag Clear

This block is one channel of a general-purpose timer. It watches a free-running counter value that arrives from outside and raises a channel event in one of two ways. In capture mode it synchronizes an external pin, detects a selected edge and stores the counter value at that moment. In compare mode it reports the cycle in which the counter starts to equal a programmed channel value. Either event sets a sticky flag. The flag drives an interrupt request when the channel's enable bit is set.

Software reaches the channel over a simple register bus with an address, a read strobe, a write strobe and write data. Read data is combinational from the current address. The control/status byte sits at address 0. The channel value register follows it one byte per address, least significant byte first.

Software clears the flag with a two-step handshake. First it reads the control byte while the flag shows 1, which arms the clear. Then it writes that byte with bit 7 at 0. If a new event lands in between, the zero write is dropped, so an event that software has not seen is never erased. A build option removes the upper mode-select bit for a reduced channel.

Top module: `cap_cmp_chan`

## Requirements
- R1: After reset the control byte (address 0), both value bytes (addresses 1 and 2) and `irq` are all 0.
- R2: Control bits 6:0 read back as last written. Bit 6 is the interrupt enable, bits 5:4 the mode pair, bits 3:2 the edge select, bit 1 toggle-on-overflow and bit 0 max-duty, and the last two are stored only. Writing 1 to bit 7 (flag) never sets the flag.
- R3: The value register is written and read a byte at a time: address 1 holds bits 7:0 and address 2 holds bits 15:8.
- R4: Capture mode is mode pair 00. There the edge select gives 00 = off, 01 = rising, 10 = falling, 11 = both. A qualifying edge on `capPin`, seen through a two-flop synchronizer, sets the flag three clock edges after the pin changes. An edge that does not qualify leaves the flag clear.
- R5: A capture loads the current counter into the value register on the same clock edge that sets the flag.
- R6: Any nonzero mode pair is compare mode. The flag sets on the clock edge after the counter first becomes equal to the value register. Holding the counter equal does not set it again, and pin edges have no effect in this mode.
- R7: `irq` is high exactly while both the flag and the enable bit are 1. A write that keeps bit 7 at 1 and clears the enable drops `irq` without clearing the flag.
- R8: A control read that returns the flag as 1, followed by a control write with bit 7 = 0, clears the flag. Any control write uses up the armed state.
- R9: A zero write to bit 7 with no qualifying read since the last event or control write leaves the flag set.
- R10: If an event occurs between the qualifying read and the zero write, the zero write leaves the flag set.
- R11: An event on the same clock edge as an armed zero write leaves the flag set.
- R12: When built with `HAS_MODE_HI` = 0, control bit 5 always reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Register address: 0 control, 1.. value bytes |
| rdEn | input | 1 | Read strobe; a control read with the flag set arms the clear |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| counter | input | CNT_W | Free-running timer count |
| capPin | input | 1 | Asynchronous capture pin |
| irq | output | 1 | Channel interrupt request |

## Verification
The bench builds two copies side by side on the same stimulus. The first uses the defaults: a 16-bit counter, two synchronizer stages and the upper mode bit present. It covers the capture edge encodings, the compare onset and every ordering of event, read and zero write in the clear handshake. The second copy is built with `HAS_MODE_HI` = 0, so the masked control bit 5 can be observed through the normal read path. The counter is held at chosen values, which makes the captured bytes and the compare cycle exact.

// File: rtl/cap_cmp_pkg.sv
package cap_cmp_pkg;

  // Capture edge selection held in control bits 3:2
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeSel_e;

  // Control/status byte, bit 7 first
  typedef struct packed {
    logic       flag;
    logic       ie;
    logic       modeHi;
    logic       modeLo;
    logic [1:0] edgeSel;
    logic       tov;
    logic       maxDuty;
  } ctrlReg_t;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic capMode;
    logic cmpMode;
    logic rise;
    logic fall;
  } chanStrb_t;

  localparam int FLAG_BIT = 7;

endpackage

// File: rtl/cap_cmp_ctrl.sv
module cap_cmp_ctrl
  import cap_cmp_pkg::*;
#(
  parameter bit HAS_MODE_HI = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ctrlSel,
  input  logic      rdEn,
  input  logic      wrEn,
  input  logic [7:0] wrData,
  input  logic      evt,
  output ctrlReg_t  ctrlQ,
  output chanStrb_t strb,
  output logic      armed,
  output logic      irq
);

  logic       wrCtrl;
  logic       rdCtrl;
  logic       flagQ;
  logic       ieQ;
  logic       modeHi;
  logic       modeLoQ;
  logic [1:0] edgeQ;
  logic       tovQ;
  logic       maxQ;
  logic       zeroWrite;

  assign wrCtrl    = wrEn && ctrlSel;
  assign rdCtrl    = rdEn && ctrlSel;
  assign zeroWrite = wrCtrl && !wrData[FLAG_BIT];

  // Plain read/write control fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieQ     <= 1'b0;
      modeLoQ <= 1'b0;
      edgeQ   <= 2'b00;
      tovQ    <= 1'b0;
      maxQ    <= 1'b0;
    end else if (wrCtrl) begin
      ieQ     <= wrData[6];
      modeLoQ <= wrData[4];
      edgeQ   <= wrData[3:2];
      tovQ    <= wrData[1];
      maxQ    <= wrData[0];
    end
  end

  // Upper mode bit exists only in the full variant
  generate
    if (HAS_MODE_HI) begin : g_modeHi
      logic modeHiQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       modeHiQ <= 1'b0;
        else if (wrCtrl) modeHiQ <= wrData[5];
      end
      assign modeHi = modeHiQ;
    end else begin : g_noModeHi
      assign modeHi = 1'b0;
    end
  endgenerate

  // Flag: events win over a clear; a clear needs the armed state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (evt) begin
      flagQ <= 1'b1;
    end else if (zeroWrite && armed) begin
      flagQ <= 1'b0;
    end
  end

  // Armed: set by a read that saw the flag, dropped by any event or control write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (evt || wrCtrl) begin
      armed <= 1'b0;
    end else if (rdCtrl && flagQ) begin
      armed <= 1'b1;
    end
  end

  always_comb begin
    ctrlQ         = '0;
    ctrlQ.flag    = flagQ;
    ctrlQ.ie      = ieQ;
    ctrlQ.modeHi  = modeHi;
    ctrlQ.modeLo  = modeLoQ;
    ctrlQ.edgeSel = edgeQ;
    ctrlQ.tov     = tovQ;
    ctrlQ.maxDuty = maxQ;
  end

  always_comb begin
    strb.capMode = ({modeHi, modeLoQ} == 2'b00);
    strb.cmpMode = !strb.capMode;
    strb.rise    = strb.capMode && (edgeQ == EDGE_RISE || edgeQ == EDGE_BOTH);
    strb.fall    = strb.capMode && (edgeQ == EDGE_FALL || edgeQ == EDGE_BOTH);
  end

  assign irq = flagQ && ieQ;

endmodule

// File: rtl/cap_cmp_dpath.sv
module cap_cmp_dpath
  import cap_cmp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanStrb_t         strb,
  input  logic              capPin,
  input  logic [CNT_W-1:0]  counter,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic              capEvt,
  output logic              cmpEvt,
  output logic [CNT_W-1:0]  value,
  output logic [7:0]        valByte
);

  localparam int VAL_BYTES = CNT_W / 8;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinSync;
  logic                   pinPrevQ;
  logic                   pinRise;
  logic                   pinFall;
  logic                   match;
  logic                   matchQ;

  // Pin synchronizer and edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      pinPrevQ <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], capPin};
      pinPrevQ <= pinSync;
    end
  end

  assign pinSync = syncQ[SYNC_STAGES-1];
  assign pinRise = pinSync && !pinPrevQ;
  assign pinFall = !pinSync && pinPrevQ;
  assign capEvt  = (strb.rise && pinRise) || (strb.fall && pinFall);

  // Compare: an event only on the first cycle of equality
  assign match = (counter == value);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchQ <= 1'b0;
    else       matchQ <= match;
  end

  assign cmpEvt = strb.cmpMode && match && !matchQ;

  // Value register, one byte lane per address; capture wins over a write
  generate
    for (genvar b = 0; b < VAL_BYTES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          value[b*8 +: 8] <= 8'h00;
        end else if (capEvt) begin
          value[b*8 +: 8] <= counter[b*8 +: 8];
        end else if (wrEn && addr == ADDR_W'(b + 1)) begin
          value[b*8 +: 8] <= wrData;
        end
      end
    end
  endgenerate

  always_comb begin
    valByte = 8'h00;
    for (int b = 0; b < VAL_BYTES; b++) begin
      if (addr == ADDR_W'(b + 1)) valByte = value[b*8 +: 8];
    end
  end

endmodule

// File: rtl/cap_cmp_chan.sv
module cap_cmp_chan
  import cap_cmp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2,
  parameter bit HAS_MODE_HI = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [CNT_W-1:0]  counter,
  input  logic              capPin,
  output logic              irq
);

  logic             ctrlSel;
  ctrlReg_t         ctrlQ;
  chanStrb_t        strb;
  logic             armed;
  logic             capEvt;
  logic             cmpEvt;
  logic             evt;
  logic [CNT_W-1:0] value;
  logic [7:0]       valByte;

  assign ctrlSel = (addr == '0);
  assign evt     = capEvt || cmpEvt;

  cap_cmp_ctrl #(
    .HAS_MODE_HI(HAS_MODE_HI)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ctrlSel(ctrlSel),
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .wrData (wrData),
    .evt    (evt),
    .ctrlQ  (ctrlQ),
    .strb   (strb),
    .armed  (armed),
    .irq    (irq)
  );

  cap_cmp_dpath #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES),
    .ADDR_W     (ADDR_W)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .capPin (capPin),
    .counter(counter),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .capEvt (capEvt),
    .cmpEvt (cmpEvt),
    .value  (value),
    .valByte(valByte)
  );

  assign rdData = ctrlSel ? ctrlQ : valByte;

endmodule

// File: rtl/cap_cmp_chk.sv
module cap_cmp_chk #(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 2,
  parameter bit HAS_MODE_HI = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              evt,
  input logic              capEvt,
  input logic              cmpEvt,
  input logic              flag,
  input logic              armed,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wrData,
  input logic [7:0]        rdData,
  input logic [CNT_W-1:0]  counter,
  input logic [CNT_W-1:0]  value
);

  // R4 / R10 / R11: an event always leaves the flag set
  p_set_on_evt_r4: assert property (@(posedge clk) disable iff (!rstN)
    evt |=> flag);

  // R5: capture stores the counter seen on the event edge
  p_cap_latch_r5: assert property (@(posedge clk) disable iff (!rstN)
    capEvt |=> (value == $past(counter)));

  // R2: the flag only rises because of an event, never from a write
  p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(evt));

  // R9: the flag only falls through an armed zero write with no event
  p_fall_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flag) |-> $past(armed && wrEn && addr == '0 && !wrData[7] && !evt));

  // R8: the armed state never outlives the flag
  p_armed_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> flag);

  // R6: capture and compare never fire together
  p_mode_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(capEvt && cmpEvt));

  // R12: reduced variant reads control bit 5 as 0
  p_mask_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == '0 && !HAS_MODE_HI) |-> !rdData[5]);

endmodule

bind cap_cmp_chan cap_cmp_chk #(
  .CNT_W      (CNT_W),
  .ADDR_W     (ADDR_W),
  .HAS_MODE_HI(HAS_MODE_HI)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .evt    (evt),
  .capEvt (capEvt),
  .cmpEvt (cmpEvt),
  .flag   (ctrlQ.flag),
  .armed  (armed),
  .wrEn   (wrEn),
  .rdEn   (rdEn),
  .addr   (addr),
  .wrData (wrData),
  .rdData (rdData),
  .counter(counter),
  .value  (value)
);

// File: tb/cap_cmp_chan_bench.sv
module cap_cmp_chan_bench;

  localparam int CLK_P  = 10;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              rdEn = 1'b0;
  logic              wrEn = 1'b0;
  logic [7:0]        wrData = '0;
  logic [CNT_W-1:0]  counter = '0;
  logic              capPin = 1'b0;
  logic [7:0]        rdData;
  logic [7:0]        rdDataNarrow;
  logic              irq;
  logic              irqNarrow;

  int errors = 0;
  int checks = 0;

  // Scoreboard item: kind 0 = rdData, 1 = irq, 2 = rdData of narrow copy
  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t expQ[$];
  logic  monReq = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cap_cmp_chan #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .HAS_MODE_HI(1'b1)) u_cap_cmp_chan (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .counter(counter), .capPin(capPin), .irq(irq));

  cap_cmp_chan #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .HAS_MODE_HI(1'b0)) u_cap_cmp_chan_narrow (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdDataNarrow), .counter(counter), .capPin(capPin), .irq(irqNarrow));

  // Monitor: samples three quarters into the cycle, away from both edges
  always @(negedge clk) begin
    #(CLK_P/4);
    if (monReq) begin
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: actual=sample expected=item");
      end else begin
        item_t it;
        logic [7:0] act;
        it = expQ.pop_front();
        act = (it.kind == 0) ? rdData : (it.kind == 1) ? {7'b0, irq} : rdDataNarrow;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rdEn = 1'b0; wrEn = 1'b0; monReq = 1'b0;
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b1; addr = a; wrData = d; monReq = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b1; addr = a; monReq = 1'b1;
    it.kind = 0; it.exp = e; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic rdNarrow(input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b1; addr = '0; monReq = 1'b1;
    it.kind = 2; it.exp = e; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic chkIrq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; monReq = 1'b1;
    it.kind = 1; it.exp = {7'b0, e}; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic setPin(input logic v);
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0; monReq = 1'b0; capPin = v;
  endtask

  task automatic setCnt(input logic [CNT_W-1:0] v);
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0; monReq = 1'b0; counter = v;
  endtask

  task automatic finishRun();
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover: actual=%0d expected=0", expQ.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    counter = 16'h1234;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rd(0, 8'h00, "R1 control after reset");
    rd(1, 8'h00, "R1 value low after reset");
    rd(2, 8'h00, "R1 value high after reset");
    chkIrq(1'b0, "R1 irq after reset");
    rdNarrow(8'h00, "R1 narrow control after reset");

    // R2 / R12: field readback, flag write of 1 ignored, masked bit 5
    wr(0, 8'hFF);
    rd(0, 8'h7F, "R2 control readback and flag write ignored");
    rdNarrow(8'h5F, "R12 narrow bit 5 masked");
    wr(0, 8'h00);
    rd(0, 8'h00, "R2 control cleared by write");

    // R3: value bytes
    wr(1, 8'hCD);
    wr(2, 8'hAB);
    rd(1, 8'hCD, "R3 value low byte");
    rd(2, 8'hAB, "R3 value high byte");

    // R4 / R5 / R7: rising capture
    wr(0, 8'h44);
    setCnt(16'h2468);
    setPin(1'b1);
    idle(4);
    chkIrq(1'b1, "R7 irq with flag and enable");
    rd(0, 8'hC4, "R4 rising edge sets flag");
    rd(1, 8'h68, "R5 captured low byte");
    rd(2, 8'h24, "R5 captured high byte");

    // R8: armed clear
    wr(0, 8'h44);
    rd(0, 8'h44, "R8 flag cleared by read then zero write");
    chkIrq(1'b0, "R7 irq low after clear");

    // R4: falling edge with rising-only select
    setPin(1'b0);
    idle(4);
    rd(0, 8'h44, "R4 falling edge ignored with rising select");

    // R9: zero write without a qualifying read
    wr(0, 8'h4C);
    setPin(1'b1);
    idle(4);
    wr(0, 8'h4C);
    rd(0, 8'hCC, "R9 unarmed zero write ignored");
    wr(0, 8'h4C);
    rd(0, 8'h4C, "R8 clear after fresh read");

    // R4: capture disabled
    wr(0, 8'h40);
    setPin(1'b0);
    idle(4);
    setPin(1'b1);
    idle(4);
    rd(0, 8'h40, "R4 edge select off ignores edges");
    setPin(1'b0);
    idle(4);

    // R10: event between read and zero write
    wr(0, 8'h48);
    setPin(1'b1);
    idle(4);
    rd(0, 8'h48, "R4 rising ignored with falling select");
    setCnt(16'h0A0B);
    setPin(1'b0);
    idle(4);
    rd(0, 8'hC8, "R4 falling edge sets flag");
    setCnt(16'h0C0D);
    setPin(1'b1);
    idle(4);
    setPin(1'b0);
    idle(4);
    wr(0, 8'h48);
    rd(0, 8'hC8, "R10 zero write after intervening event ignored");
    rd(1, 8'h0D, "R5 second capture low byte");
    wr(0, 8'h48);
    rd(0, 8'h48, "R8 clear after re-read");

    // R6: compare mode
    setCnt(16'h0000);
    wr(1, 8'h34);
    wr(2, 8'h12);
    wr(0, 8'h50);
    setPin(1'b1);
    idle(4);
    setPin(1'b0);
    idle(4);
    rd(0, 8'h50, "R6 pin edges ignored in compare mode");
    setCnt(16'h1234);
    rd(0, 8'hD0, "R6 compare match sets flag");
    rd(1, 8'h34, "R6 value unchanged by compare");
    wr(0, 8'h50);
    rd(0, 8'h50, "R6 held match does not set again");
    setCnt(16'h1235);
    setCnt(16'h1234);
    rd(0, 8'hD0, "R6 new match onset sets flag");

    // R11: event on the same edge as an armed zero write
    setCnt(16'h1235);
    @(negedge clk);
    rdEn = 1'b0; monReq = 1'b0; wrEn = 1'b1; addr = 0; wrData = 8'h50; counter = 16'h1234;
    rd(0, 8'hD0, "R11 same-edge event keeps flag");

    // R7: disable interrupt while keeping the flag
    wr(0, 8'h90);
    rd(0, 8'h90, "R7 flag kept when writing bit 7 as 1");
    chkIrq(1'b0, "R7 irq low with enable cleared");

    idle(2);
    finishRun();
  end

endmodule